// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Busy Arbitration

This block is a synchronous memory with two equal ports, left and right, each able to read or write any word in every clock cycle. When both ports are enabled on the same word, an arbiter gives the word to the port that got there first and raises a busy flag toward the other port. While its busy flag is high, a port cannot change memory. A write held by the losing port goes into memory in the first cycle its busy flag is low again.

A strap input puts the block in slave mode. In that mode the internal arbiter has no effect. Each port's busy flag comes in from outside, for example from a master device of the same kind when two are placed side by side to build a wider word. An incoming busy flag blocks writes in the same way as an internal one. Reads are never blocked. Read data is registered and shows the array contents as they were before any write at the same clock edge.

Top module: `dpr_busy_ram`

## Requirements
- R1: In master mode (slave_mode=0), a port's busy_out is high only when both enables are high and the two addresses are equal (a conflict). Otherwise both busy_out are low.
- R2: When a conflict starts, the winner is the port that was enabled at its current address in the previous cycle while the other port was not. busy_out is raised on the other port only.
- R3: When a conflict starts and neither port (or both) was already present at its current address in the previous cycle, the left port wins and r_busy_out is raised.
- R4: In master mode during a conflict, exactly one busy_out is high. The two busy_out are never high together.
- R5: As long as a conflict lasts from one cycle to the next, the same port stays the winner.
- R6: A port whose busy_out is high does not modify memory, even when it has en=1 and wr=1.
- R7: busy_out falls in the same cycle that the conflict condition goes away. A write that the losing port still holds then commits at that clock edge.
- R8: In slave mode (slave_mode=1), each busy_out equals that port's busy_in and the internal arbitration has no effect. A high busy_in blocks that port's write.
- R9: After a clock edge at which a port had en=1 and wr=0, its rdata equals the word at its address from before the writes of that edge. At any other edge, rdata holds its value.
- R10: If both ports write the same address unblocked in the same cycle (possible only in slave mode), the left port's data is stored.
- R11: While rst_n is low, both busy_out are low in master mode with idle ports, and both rdata registers clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: busy flags are taken from busy_in; 0: internal arbitration |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_addr | input | AW | Left port address |
| l_wdata | input | DW | Left port write data |
| l_rdata | output | DW | Left port registered read data |
| l_busy_in | input | 1 | Left busy flag from outside (slave mode) |
| l_busy_out | output | 1 | Left busy flag |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_addr | input | AW | Right port address |
| r_wdata | input | DW | Right port write data |
| r_rdata | output | DW | Right port registered read data |
| r_busy_in | input | 1 | Right busy flag from outside (slave mode) |
| r_busy_out | output | 1 | Right busy flag |

## Verification
The bench targets four situations:
- A conflict that starts when one port moves onto the other's address. A design that judges arrival by port rather than by history would flag the wrong side.
- A conflict where both ports arrive in the same cycle. Here a broken tie rule would raise both flags or neither.
- A blocked write that is still held when the winner leaves. It must land in that cycle, not be lost and not be early, which a readback on the other port exposes.
- Slave mode with an external flag, and a same-address double write. A design that still used its own arbiter, or let the right port win, would store the wrong word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    output logic          conflict,
    output logic          busy_l,
    output logic          busy_r
);
    typedef struct packed {
        owner_e        owner;
        logic          l_en;
        logic [AW-1:0] l_addr;
        logic          r_en;
        logic [AW-1:0] r_addr;
    } arb_state_t;

    arb_state_t s_d, s_q;
    logic   l_was_here, r_was_here;
    owner_e fresh_winner, cur_winner;

    always_comb begin
        conflict     = l_en & r_en & (l_addr == r_addr);
        l_was_here   = s_q.l_en & (s_q.l_addr == l_addr);
        r_was_here   = s_q.r_en & (s_q.r_addr == r_addr);
        fresh_winner = (r_was_here & ~l_was_here) ? OWN_RIGHT : OWN_LEFT;
        cur_winner   = (s_q.owner != OWN_NONE) ? s_q.owner : fresh_winner;
        busy_l       = conflict & (cur_winner == OWN_RIGHT);
        busy_r       = conflict & (cur_winner == OWN_LEFT);

        s_d        = s_q;
        s_d.owner  = conflict ? cur_winner : OWN_NONE;
        s_d.l_en   = l_en;
        s_d.l_addr = l_addr;
        s_d.r_en   = r_en;
        s_d.r_addr = r_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{owner: OWN_NONE, l_en: 1'b0, l_addr: '0, r_en: 1'b0, r_addr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    AST_BUSY_NEEDS_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_l | busy_r) |-> (l_en && r_en && l_addr == r_addr)); // R1
    AST_BUSY_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_l && busy_r)); // R4
    AST_CONFLICT_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && l_addr == r_addr) |-> $countones({busy_l, busy_r}) == 1); // R4
    AST_WINNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && $past(conflict) && $past(rst_n)) |-> (busy_l == $past(busy_l))); // R5
endmodule

// File: rtl/dpr_port_gate.sv
module dpr_port_gate (
    input  logic slave_mode,
    input  logic busy_arb,
    input  logic busy_ext,
    input  logic en,
    input  logic wr,
    output logic busy_eff,
    output logic wr_commit,
    output logic rd_req
);
    always_comb begin
        busy_eff  = slave_mode ? busy_ext : busy_arb;
        wr_commit = en & wr & ~busy_eff;
        rd_req    = en & ~wr;
    end
endmodule

// File: rtl/dpr_mem.sv
module dpr_mem #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic          a_re,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic          b_re,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } rd_t;

    logic [DW-1:0] store [DEPTH];
    rd_t rd_d, rd_q;

    // Port a is applied last so that it wins a same-word double write.
    always_ff @(posedge clk) begin
        if (b_we) store[b_addr] <= b_wdata;
        if (a_we) store[a_addr] <= a_wdata;
    end

    always_comb begin
        rd_d = rd_q;
        if (a_re) rd_d.a = store[a_addr];
        if (b_re) rd_d.b = store[b_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign a_rdata = rd_q.a;
    assign b_rdata = rd_q.b;

    AST_RDATA_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        !a_re |=> $stable(a_rdata)); // R9
    AST_RDATA_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        !b_re |=> $stable(b_rdata)); // R9
endmodule

// File: rtl/dpr_busy_ram.sv
module dpr_busy_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slave_mode,
    input  logic          l_en,
    input  logic          l_wr,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic          l_busy_in,
    output logic          l_busy_out,
    input  logic          r_en,
    input  logic          r_wr,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    input  logic          r_busy_in,
    output logic          r_busy_out
);
    localparam int NPORT = 2;

    logic             conflict;
    logic [NPORT-1:0] busy_arb, busy_ext, en_v, wr_v, busy_eff, wr_commit, rd_req;

    assign busy_ext = {r_busy_in, l_busy_in};
    assign en_v     = {r_en, l_en};
    assign wr_v     = {r_wr, l_wr};

    dpr_arbiter #(.AW(AW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .l_en     (l_en),
        .l_addr   (l_addr),
        .r_en     (r_en),
        .r_addr   (r_addr),
        .conflict (conflict),
        .busy_l   (busy_arb[0]),
        .busy_r   (busy_arb[1])
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpr_port_gate u_gate (
            .slave_mode (slave_mode),
            .busy_arb   (busy_arb[p]),
            .busy_ext   (busy_ext[p]),
            .en         (en_v[p]),
            .wr         (wr_v[p]),
            .busy_eff   (busy_eff[p]),
            .wr_commit  (wr_commit[p]),
            .rd_req     (rd_req[p])
        );
    end

    dpr_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (wr_commit[0]),
        .a_re    (rd_req[0]),
        .a_addr  (l_addr),
        .a_wdata (l_wdata),
        .a_rdata (l_rdata),
        .b_we    (wr_commit[1]),
        .b_re    (rd_req[1]),
        .b_addr  (r_addr),
        .b_wdata (r_wdata),
        .b_rdata (r_rdata)
    );

    assign l_busy_out = busy_eff[0];
    assign r_busy_out = busy_eff[1];

    AST_MASTER_BUSY_TRACKS_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !conflict) |-> !(l_busy_out || r_busy_out)); // R1
    AST_SLAVE_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (l_busy_out == l_busy_in && r_busy_out == r_busy_in)); // R8
endmodule

// File: tb/dpr_busy_ram_test.sv
`timescale 1ns/1ps
module dpr_busy_ram_test;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_mode = 1'b0;
    logic l_en = 0, l_wr = 0, r_en = 0, r_wr = 0, l_busy_in = 0, r_busy_in = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_busy_out, r_busy_out;

    always #10 clk = ~clk;

    dpr_busy_ram #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model state, built from the requirements
    logic [DW-1:0] mm [DEPTH];
    logic          pl_en, pr_en;
    logic [AW-1:0] pl_a, pr_a;
    int            own;   // 0 none, 1 left, 2 right
    logic [DW-1:0] exp_lr, exp_rr;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit conflict_of(input logic le, input logic [AW-1:0] la,
                                       input logic re, input logic [AW-1:0] ra);
        return le && re && (la == ra);
    endfunction

    function automatic int winner_of(input logic le, input logic [AW-1:0] la,
                                     input logic re, input logic [AW-1:0] ra);
        bit lo, ro;
        if (own != 0) return own;
        lo = pl_en && (pl_a == la);
        ro = pr_en && (pr_a == ra);
        return (ro && !lo) ? 2 : 1;
    endfunction

    task automatic model_reset();
        pl_en = 0; pr_en = 0; pl_a = '0; pr_a = '0; own = 0;
        exp_lr = '0; exp_rr = '0;
    endtask

    task automatic step(input logic le, input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                        input logic re, input logic rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                        input logic sm, input logic bil, input logic bir);
        bit cf, eb_l, eb_r, fresh;
        int w;
        string tag;
        @(negedge clk);
        l_en = le; l_wr = lw; l_addr = la; l_wdata = ld;
        r_en = re; r_wr = rw; r_addr = ra; r_wdata = rd;
        slave_mode = sm; l_busy_in = bil; r_busy_in = bir;
        #1;
        cf = conflict_of(le, la, re, ra);
        fresh = (own == 0);
        w = winner_of(le, la, re, ra);
        if (sm) begin
            eb_l = bil; eb_r = bir; tag = "R8 busy follows input";
        end else begin
            eb_l = cf && (w == 2);
            eb_r = cf && (w == 1);
            if (!cf)                              tag = "R1 no conflict";
            else if (!fresh)                      tag = "R5 winner held";
            else if (w == 1 && !(pl_en && pl_a == la && !(pr_en && pr_a == ra)))
                                                  tag = "R3 tie to left";
            else                                  tag = "R2 first arrival";
        end
        chk(l_busy_out === eb_l, {tag, " l_busy"}, 32'(l_busy_out), 32'(eb_l));
        chk(r_busy_out === eb_r, {tag, " r_busy"}, 32'(r_busy_out), 32'(eb_r));
        if (!sm && cf)
            chk((l_busy_out + r_busy_out) == 1, "R4 exactly one busy", {l_busy_out, r_busy_out}, 32'd1);
        @(posedge clk);
        #1;
        if (le && !lw) exp_lr = mm[la];
        if (re && !rw) exp_rr = mm[ra];
        if (re && rw && !eb_r) mm[ra] = rd;
        if (le && lw && !eb_l) mm[la] = ld;
        own = cf ? w : 0;
        pl_en = le; pl_a = la; pr_en = re; pr_a = ra;
        chk(l_rdata === exp_lr, "R9 l_rdata", 32'(l_rdata), 32'(exp_lr));
        chk(r_rdata === exp_rr, "R9 r_rdata", 32'(r_rdata), 32'(exp_rr));
    endtask

    task automatic idle();
        step(0, 0, '0, '0, 0, 0, '0, '0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(l_busy_out === 1'b0 && r_busy_out === 1'b0, "R11 busy low in reset",
            {l_busy_out, r_busy_out}, 32'd0);
        chk(l_rdata === '0 && r_rdata === '0, "R11 rdata cleared", {l_rdata, r_rdata}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Fill the low words used by the test
        for (int a = 0; a < 16; a++)
            step(1, 1, AW'(a), DW'(8'h10 + a), 0, 0, '0, '0, 0, 0, 0);
        idle();

        // R2: left is present first, right arrives and loses; R6: blocked write leaves memory
        step(1, 1, 10'd3, 8'hA1, 0, 0, '0, '0, 0, 0, 0);
        step(1, 0, 10'd3, 8'h00, 1, 1, 10'd3, 8'hB2, 0, 0, 0);
        chk(r_busy_out === 1'b1, "R2 late right port busy", 32'(r_busy_out), 32'd1);
        step(1, 0, 10'd3, 8'h00, 1, 1, 10'd3, 8'hB2, 0, 0, 0);
        chk(l_rdata === 8'hA1, "R6 blocked write did not land", 32'(l_rdata), 32'hA1);
        // R7: winner leaves, held write commits in that cycle
        step(1, 0, 10'd4, 8'h00, 1, 1, 10'd3, 8'hB2, 0, 0, 0);
        chk(r_busy_out === 1'b0, "R7 busy falls with conflict", 32'(r_busy_out), 32'd0);
        step(1, 0, 10'd3, 8'h00, 0, 0, '0, '0, 0, 0, 0);
        chk(l_rdata === 8'hB2, "R7 held write committed", 32'(l_rdata), 32'hB2);
        idle();

        // R2 reversed: right present, left moves onto it
        step(1, 0, 10'd7, 8'h00, 1, 1, 10'd8, 8'hC3, 0, 0, 0);
        step(1, 1, 10'd8, 8'hD4, 1, 1, 10'd8, 8'hC3, 0, 0, 0);
        chk(l_busy_out === 1'b1 && r_busy_out === 1'b0, "R2 left moved onto right",
            {l_busy_out, r_busy_out}, 32'h2);
        idle();

        // R3: both arrive in the same cycle
        step(1, 1, 10'd9, 8'h55, 1, 1, 10'd9, 8'h66, 0, 0, 0);
        chk(r_busy_out === 1'b1 && l_busy_out === 1'b0, "R3 simultaneous tie",
            {l_busy_out, r_busy_out}, 32'h1);
        step(0, 0, '0, '0, 1, 0, 10'd9, '0, 0, 0, 0);
        chk(r_rdata === 8'h55, "R3 left data kept", 32'(r_rdata), 32'h55);

        // R5: loser drops and re-presents while winner stays
        step(1, 1, 10'd2, 8'h21, 0, 0, '0, '0, 0, 0, 0);
        step(1, 1, 10'd2, 8'h22, 1, 1, 10'd2, 8'h99, 0, 0, 0);
        step(1, 1, 10'd2, 8'h23, 0, 0, '0, '0, 0, 0, 0);
        step(1, 1, 10'd2, 8'h24, 1, 1, 10'd2, 8'h98, 0, 0, 0);
        chk(r_busy_out === 1'b1, "R5 winner keeps priority", 32'(r_busy_out), 32'd1);
        idle();

        // R8: slave mode, external busy blocks left even without conflict
        step(1, 1, 10'd6, 8'hEE, 0, 0, '0, '0, 1, 1, 0);
        chk(l_busy_out === 1'b1, "R8 external busy seen", 32'(l_busy_out), 32'd1);
        step(0, 0, '0, '0, 1, 0, 10'd6, '0, 1, 0, 0);
        chk(r_rdata === 8'h16, "R8 slave busy blocked write", 32'(r_rdata), 32'h16);

        // R10: slave mode, both write one word unblocked
        step(1, 1, 10'd5, 8'h5A, 1, 1, 10'd5, 8'hA5, 1, 0, 0);
        step(1, 0, 10'd5, '0, 0, 0, '0, '0, 1, 0, 0);
        chk(l_rdata === 8'h5A, "R10 left wins double write", 32'(l_rdata), 32'h5A);
        idle();

        // Random traffic over a small address window
        for (int i = 0; i < 3000; i++) begin
            logic sm;
            sm = ($urandom % 8) == 0;
            step($urandom % 4 != 0, $urandom % 2, AW'($urandom % 4), DW'($urandom),
                 $urandom % 4 != 0, $urandom % 2, AW'($urandom % 4), DW'($urandom),
                 sm, sm && ($urandom % 2), sm && ($urandom % 2));
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule